// File: doc/BRIEF.md
# One-Bit Stream Deglitch and Blanking Receiver

This block receives the data and clock lines of an isolated one-bit sigma-delta modulator and feeds a decimation filter that runs on the local system clock. The modulator clock, the data line and a switching-edge marker from the power-stage controller are all asynchronous to the system clock. Each one first passes through a two-flop synchronizer. After that, the receiver takes one sample per rising edge of the modulator clock and emits it as a single-cycle strobe together with an invalid flag.

Data-line pulses shorter than a programmable width, counted in system clocks, are treated as glitches and never become data. If the qualified data level changes more than once within one modulator clock period, the sample is marked as an impossible transition. Each marker edge opens a blanking window whose length is given in modulator samples. While the window is open, the receiver outputs a mid-scale pattern of alternating ones and zeros and flags every sample as invalid. Three saturating counters record rejected glitches, opened windows and invalid samples, so that disturbances can be correlated with switching activity.

Top module: `bitstream_guard`

## Requirements
- R1: Each rising edge of `modClk` produces exactly one `bitValid` pulse of one system-clock cycle. When no fault or blanking applies, `bitOut` carries the `modData` level held before that edge and `bitInvalid` is 0.
- R2: A `modData` pulse lasting fewer than `minWidth` system clocks is rejected. `bitOut` keeps the surrounding level, that sample has `bitInvalid`=1, and `glitchCount` rises by one.
- R3: If the qualified data level changes two or more times between consecutive `modClk` rising edges, the next sample has `bitInvalid`=1 and `bitOut` equal to the final qualified level.
- R4: A rising edge on `edgeMark` while `blankLen`=N>0 makes the next N samples (the first is the sample that ends the current modulator period) come out as 1,0,1,0,... with `bitInvalid`=1. It also increments `blankCount` by one.
- R5: A rising edge on `edgeMark` while `blankLen`=0 has no effect on samples and leaves `blankCount` unchanged.
- R6: A marker edge that arrives while a window is still open reloads the count to `blankLen` and restarts the pattern at 1.
- R7: `bitInvalid` is only ever high together with `bitValid`. `invalidCount` increases by exactly one for each invalid sample and does not change otherwise.
- R8: All counters stop at 2^CNT_W-1 instead of wrapping, and they never decrease except on clear.
- R9: A high `clear` sets all three counters to zero on the next clock edge.
- R10: After reset, `bitValid`, `bitOut`, `bitInvalid` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous counter clear |
| modClk | input | 1 | Modulator clock (asynchronous) |
| modData | input | 1 | Modulator one-bit data (asynchronous) |
| edgeMark | input | 1 | Switching-edge marker (asynchronous) |
| minWidth | input | RUN_W (4) | Minimum legal pulse width in system clocks |
| blankLen | input | BLANK_W (8) | Blanking window length in samples, 0 disables |
| bitOut | output | 1 | Sample bit toward the filter |
| bitValid | output | 1 | One-cycle strobe per sample |
| bitInvalid | output | 1 | Sample is not trusted |
| glitchCount | output | CNT_W (8) | Saturating count of rejected pulses |
| blankCount | output | CNT_W (8) | Saturating count of opened windows |
| invalidCount | output | CNT_W (8) | Saturating count of invalid samples |

## Verification
A blanking timer with the wrong count or a wrong pattern phase shows up at the first sample strobe after a marker. The bench sees a substituted bit where a real one was expected, or the reverse, within one modulator period. Run-length or qualified-level errors in the glitch filter appear as wrong `bitOut` values or missing invalid flags on the very sample that contains the disturbance. Interval flags that are not cleared cause invalid marks to spread onto the following clean sample. Counter faults accumulate quietly and only become visible when the counts are compared after a burst or at the saturation limit.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  // strobes from control toward datapath, one set per system clock
  typedef struct packed {
    logic tick;     // synchronized modulator clock rising edge
    logic subst;    // this sample is blanked
    logic altBit;   // substitute bit for this sample
    logic flagBad;  // glitch or impossible transition in the closing interval
    logic winOpen;  // a blanking window opened this cycle
  } bsgStrobe_t;
endpackage

// File: rtl/bsg_sync.sv
module bsg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= asyncIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/bsg_ctrl.sv
module bsg_ctrl
  import bsg_pkg::*;
#(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkSync,
  input  logic               markSync,
  input  logic [BLANK_W-1:0] blankLen,
  input  logic               glitchEv,
  input  logic               qChange,
  output bsgStrobe_t         strobe
);
  logic               clkPrev, markPrev;
  logic [BLANK_W-1:0] blankRem, remCur;
  logic               altReg, altCur;
  logic               glitchPend;
  logic [1:0]         transCnt;
  logic               tick, markRise, winOpen, subst;

  assign tick     = clkSync & ~clkPrev;
  assign markRise = markSync & ~markPrev;
  assign winOpen  = markRise && (blankLen != '0);

  always_comb begin
    remCur = winOpen ? blankLen : blankRem;
    altCur = winOpen ? 1'b1 : altReg;
  end
  assign subst = tick && (remCur != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev    <= 1'b0;
      markPrev   <= 1'b0;
      blankRem   <= '0;
      altReg     <= 1'b1;
      glitchPend <= 1'b0;
      transCnt   <= '0;
    end else begin
      clkPrev  <= clkSync;
      markPrev <= markSync;
      blankRem <= subst ? remCur - 1'b1 : remCur;
      altReg   <= subst ? ~altCur : altCur;
      if (tick) begin
        // events in the tick cycle belong to the next interval
        glitchPend <= glitchEv;
        transCnt   <= {1'b0, qChange};
      end else begin
        glitchPend <= glitchPend | glitchEv;
        if (qChange && transCnt != 2'd3) transCnt <= transCnt + 2'd1;
      end
    end
  end

  assign strobe.tick    = tick;
  assign strobe.subst   = subst;
  assign strobe.altBit  = altCur;
  assign strobe.flagBad = glitchPend | (transCnt >= 2'd2);
  assign strobe.winOpen = winOpen;
endmodule

// File: rtl/bsg_datapath.sv
module bsg_datapath
  import bsg_pkg::*;
#(
  parameter int RUN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             dataSync,
  input  logic [RUN_W-1:0] minWidth,
  input  bsgStrobe_t       strobe,
  output logic             glitchEv,
  output logic             qChange,
  output logic             bitOut,
  output logic             bitValid,
  output logic             bitInvalid,
  output logic [CNT_W-1:0] glitchCount,
  output logic [CNT_W-1:0] blankCount,
  output logic [CNT_W-1:0] invalidCount
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               NUM_CNT = 3;

  logic             dPrev, qData, changed;
  logic [RUN_W-1:0] runLen, runNext;
  logic             invalidEv;
  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0] cnt [NUM_CNT];

  assign changed  = dataSync != dPrev;
  assign runNext  = changed ? RUN_W'(1) : ((runLen == RUN_MAX) ? runLen : runLen + 1'b1);
  assign qChange  = (dataSync != qData) && (runNext >= minWidth);
  // a level that ends before it qualified was an illegal short pulse
  assign glitchEv = changed && (dPrev != qData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dPrev  <= 1'b0;
      qData  <= 1'b0;
      runLen <= '0;
    end else begin
      dPrev  <= dataSync;
      runLen <= runNext;
      if (qChange) qData <= dataSync;
    end
  end

  assign invalidEv = strobe.tick & (strobe.subst | strobe.flagBad);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitOut     <= 1'b0;
      bitValid   <= 1'b0;
      bitInvalid <= 1'b0;
    end else begin
      bitValid   <= strobe.tick;
      bitInvalid <= invalidEv;
      if (strobe.tick) bitOut <= strobe.subst ? strobe.altBit : qData;
    end
  end

  assign incVec = {invalidEv, strobe.winOpen, glitchEv};

  always_ff @(posedge clk or negedge rstN) begin
    for (int k = 0; k < NUM_CNT; k++) begin
      if (!rstN)                              cnt[k] <= '0;
      else if (clear)                         cnt[k] <= '0;
      else if (incVec[k] && cnt[k] != CNT_MAX) cnt[k] <= cnt[k] + 1'b1;
    end
  end

  assign glitchCount  = cnt[0];
  assign blankCount   = cnt[1];
  assign invalidCount = cnt[2];
endmodule

// File: rtl/bitstream_guard.sv
module bitstream_guard
  import bsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W       = 4,
  parameter int BLANK_W     = 8,
  parameter int CNT_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               modClk,
  input  logic               modData,
  input  logic               edgeMark,
  input  logic [RUN_W-1:0]   minWidth,
  input  logic [BLANK_W-1:0] blankLen,
  output logic               bitOut,
  output logic               bitValid,
  output logic               bitInvalid,
  output logic [CNT_W-1:0]   glitchCount,
  output logic [CNT_W-1:0]   blankCount,
  output logic [CNT_W-1:0]   invalidCount
);
  logic [2:0] syncBus;
  logic       glitchEv, qChange;
  bsgStrobe_t strobe;

  bsg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({edgeMark, modClk, modData}),
    .syncOut(syncBus)
  );

  bsg_ctrl #(.BLANK_W(BLANK_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .clkSync(syncBus[1]), .markSync(syncBus[2]),
    .blankLen(blankLen), .glitchEv(glitchEv), .qChange(qChange),
    .strobe(strobe)
  );

  bsg_datapath #(.RUN_W(RUN_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .clear(clear),
    .dataSync(syncBus[0]), .minWidth(minWidth), .strobe(strobe),
    .glitchEv(glitchEv), .qChange(qChange),
    .bitOut(bitOut), .bitValid(bitValid), .bitInvalid(bitInvalid),
    .glitchCount(glitchCount), .blankCount(blankCount), .invalidCount(invalidCount)
  );
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             bitValid,
  input logic             bitInvalid,
  input logic [CNT_W-1:0] glitchCount,
  input logic [CNT_W-1:0] blankCount,
  input logic [CNT_W-1:0] invalidCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  assert_invalid_needs_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitInvalid |-> bitValid);

  assert_invalid_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && bitInvalid && !$past(clear) && $past(invalidCount) != CNT_MAX)
      |-> invalidCount == CNT_W'($past(invalidCount) + 1'b1));

  assert_invalid_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!(bitValid && bitInvalid) && !$past(clear)) |-> invalidCount == $past(invalidCount));

  assert_glitch_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (glitchCount == CNT_MAX && !clear) |=> glitchCount == CNT_MAX);

  assert_blank_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> blankCount >= $past(blankCount));

  assert_glitch_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> glitchCount >= $past(glitchCount));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (glitchCount == '0 && blankCount == '0 && invalidCount == '0));
endmodule

bind bitstream_guard bsg_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .clear(clear),
  .bitValid(bitValid), .bitInvalid(bitInvalid),
  .glitchCount(glitchCount), .blankCount(blankCount), .invalidCount(invalidCount)
);

// File: tb/test_bitstream_guard.sv
`timescale 1ns/1ps
module test_bitstream_guard;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       modClk = 1'b0;
  logic       modData = 1'b0;
  logic       edgeMark = 1'b0;
  logic [3:0] minWidth = 4'd3;
  logic [7:0] blankLen = 8'd0;
  logic       bitOut, bitValid, bitInvalid;
  logic [7:0] glitchCount, blankCount, invalidCount;

  int errors = 0;
  int checks = 0;
  logic  expBit [0:1023];
  logic  expInv [0:1023];
  string expReq [0:1023];
  int wrPtr = 0;
  int rdPtr = 0;
  int gExp = 0, bExp = 0, iExp = 0;
  int remM = 0;
  logic altM = 1'b1;

  always #4 clk = ~clk;

  bitstream_guard i_bitstream_guard (
    .clk(clk), .rstN(rstN), .clear(clear),
    .modClk(modClk), .modData(modData), .edgeMark(edgeMark),
    .minWidth(minWidth), .blankLen(blankLen),
    .bitOut(bitOut), .bitValid(bitValid), .bitInvalid(bitInvalid),
    .glitchCount(glitchCount), .blankCount(blankCount), .invalidCount(invalidCount)
  );

  function automatic int satInc(input int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // sample monitor, away from the active edge
  always @(negedge clk) begin
    if (rstN && bitValid) begin
      if (rdPtr >= wrPtr) begin
        check("R1 extra sample", 1, 0);
      end else begin
        check({expReq[rdPtr], " bit"}, int'(bitOut), int'(expBit[rdPtr]));
        check({expReq[rdPtr], " invalid"}, int'(bitInvalid), int'(expInv[rdPtr]));
        rdPtr++;
      end
    end
  end

  // kind: 0 clean, 1 short glitch, 2 double transition
  task automatic sendBit(input logic b, input int kind, input logic mark);
    logic inv;
    if (mark && blankLen != 8'd0) begin
      remM = int'(blankLen); altM = 1'b1; bExp = satInc(bExp);
    end
    if (kind == 1) gExp = satInc(gExp);
    if (remM > 0) begin
      expBit[wrPtr] = altM; expInv[wrPtr] = 1'b1;
      expReq[wrPtr] = "R4/R6 blank";
      altM = ~altM; remM--; inv = 1'b1;
    end else begin
      expBit[wrPtr] = b; inv = (kind != 0); expInv[wrPtr] = inv;
      expReq[wrPtr] = (kind == 1) ? "R2 glitch" : (kind == 2) ? "R3 double" : "R1 clean";
    end
    if (inv) iExp = satInc(iExp);
    wrPtr++;
    for (int cyc = 0; cyc < 32; cyc++) begin
      @(posedge clk); #1;
      case (cyc)
        0:  begin modClk = 1'b0; modData = b; edgeMark = mark; end
        4:  edgeMark = 1'b0;
        5:  if (kind != 0) modData = ~b;
        6:  if (kind == 1) modData = b;
        10: if (kind == 2) modData = b;
        16: modClk = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic flush();
    @(posedge clk); #1; modClk = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkCounts(input string tag);
    check({tag, " R2 glitchCount"}, int'(glitchCount), gExp);
    check({tag, " R4 blankCount"}, int'(blankCount), bExp);
    check({tag, " R7 invalidCount"}, int'(invalidCount), iExp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd2024);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 bitValid", int'(bitValid), 0);
    check("R10 bitOut", int'(bitOut), 0);
    check("R10 bitInvalid", int'(bitInvalid), 0);
    check("R10 counts", int'(glitchCount) + int'(blankCount) + int'(invalidCount), 0);
    #1 rstN = 1'b1;
    repeat (4) @(posedge clk);

    // R1 clean samples
    sendBit(1, 0, 0); sendBit(0, 0, 0); sendBit(1, 0, 0);
    sendBit(1, 0, 0); sendBit(0, 0, 0); sendBit(0, 0, 0);
    // R2 short pulses
    sendBit(1, 1, 0); sendBit(0, 1, 0);
    // R3 two qualified changes in one period
    sendBit(0, 2, 0); sendBit(1, 2, 0);
    // R5 marker with blanking disabled
    blankLen = 8'd0;
    sendBit(1, 0, 1); sendBit(0, 0, 0);
    flush();
    check("R5 blankCount", int'(blankCount), 0);
    // R4 window of three samples
    blankLen = 8'd3;
    sendBit(0, 0, 1); sendBit(0, 0, 0); sendBit(0, 0, 0); sendBit(0, 0, 0);
    // R6 restart while open
    blankLen = 8'd5;
    sendBit(1, 0, 1); sendBit(1, 0, 0); sendBit(1, 0, 1);
    for (int i = 0; i < 6; i++) sendBit(1, 0, 0);
    flush();
    checkCounts("directed");

    // constrained random
    for (int i = 0; i < 200; i++) begin
      int unsigned r;
      int kind;
      logic mark;
      r = $urandom_range(99);
      kind = (r < 70) ? 0 : (r < 85) ? 1 : 2;
      mark = ($urandom_range(99) < 8);
      if (mark) blankLen = 8'($urandom_range(6));
      sendBit(1'($urandom_range(1)), kind, mark);
    end
    flush();
    checkCounts("random");

    // R9 clear
    @(posedge clk); #1 clear = 1'b1;
    @(posedge clk); #1 clear = 1'b0;
    @(negedge clk);
    gExp = 0; bExp = 0; iExp = 0;
    check("R9 glitchCount", int'(glitchCount), 0);
    check("R9 blankCount", int'(blankCount), 0);
    check("R9 invalidCount", int'(invalidCount), 0);

    // R8 saturation through a long window
    blankLen = 8'd255;
    sendBit(0, 0, 1);
    for (int i = 0; i < 269; i++) sendBit(1'($urandom_range(1)), (i % 3 == 0) ? 1 : 0, 0);
    flush();
    check("R8 invalidCount saturated", int'(invalidCount), 255);
    checkCounts("saturation");
    check("R1 all samples seen", rdPtr, wrPtr);
    finishRun();
  end
endmodule